// File: doc/BRIEF.md
# Attribute-Typed Status and Control Register Bank

This block is a small bank of memory-mapped registers. Each bit carries a fixed access attribute, and that attribute decides how the bit reacts to bus writes, to bus reads and to hardware events. The supported attributes are:

- plain read/write
- read-only live status
- write-only control
- write-one-to-clear event flag
- clear-on-read event flag
- one-cycle self-clearing command
- latch-high status
- latch-low status
- reserved

A package function places the attributes. A second function marks the few bits that keep their value through a software reset.

Software reaches the bank through a simple synchronous bus: address, read strobe, write strobe, write data and registered read data. Hardware reaches it through a flat vector of per-bit condition inputs, indexed as register × data width + bit. Each condition acts according to its bit's attribute:

- a live value for read-only bits
- a set event for event flags
- a cause for latched bits

A second flat vector gives hardware the stored value of every bit.

The bus decoder classifies each cycle into one of three operations: OP_IDLE, OP_READ or OP_WRITE. A write strobe takes OP_WRITE even when the read strobe is also high. Every latched bit runs through two states, held and released. A new event moves it to held. A bus read moves it to released, and from there the bit follows the live cause.

Top module: `rb_attr_bank`

## Requirements
- R1: A read (bus_rd high, bus_wr low) loads bus_rdata at that clock edge with the addressed register. In any other cycle bus_rdata holds, including a cycle where both strobes are high, in which case only the write takes effect.
- R2: Register 0 bits 3:0 are read/write: a write stores wdata, a read returns it, and their default is 4'b0001.
- R3: Register 0 bits 5:4 are write-only: a write updates hw_q[5:4], while a read always returns 0 in those positions.
- R4: Register 0 bit 6 is self-clearing: writing 1 drives hw_q[6] high for exactly one cycle after the write edge, writing 0 leaves it low, and later reads return 0.
- R5: Register 1 bits 1:0 are read-only: a read returns hw_cond[9:8] as sampled at the read edge, and writes have no effect.
- R6: Register 1 bits 3:2 are write-one-to-clear flags set by hw_cond[11:10]: writing 1 clears, writing 0 has no effect, and a set in the same cycle as a clearing write wins.
- R7: Register 1 bits 5:4 are clear-on-read flags set by hw_cond[13:12]: the read returns the pre-clear value, the flag is clear from the following read, writes are ignored, and a set in the read cycle wins.
- R8: Register 2 bits 1:0 are latch-high, with cause hw_cond[17:16]: the bit rises with the cause and stays high until read, even after the cause has gone. After the read it follows the cause and falls once the cause is gone.
- R9: Register 2 bits 3:2 are latch-low, with cause hw_cond[19:18], and default 1: the bit falls while the cause is present and stays low until read. After the read it rises once the cause is removed.
- R10: Reserved bits read as 0 and ignore writes. These are register 0 bit 7, register 1 bits 7:6, register 2 bits 7:4 and all of register 3.
- R11: A sw_rst cycle returns every bit to its default except register 0 bits 3:2 and register 1 bit 3, which keep their state.
- R12: rst_n low returns every bit to its default, including the bits named in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| bus_addr | input | AW | Register index |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| hw_cond | input | NREG*DW | Per-bit hardware condition |
| hw_q | output | NREG*DW | Per-bit stored value for hardware |

## Verification
Read data is due at the falling edge that follows the rising edge which sampled the read strobe. Read side effects (a clear-on-read clear or a latch release) therefore show only on the next read access. A written value, and the one-cycle pulse of a self-clearing bit, appear on hw_q at the falling edge right after the write edge, and the pulse is gone one cycle later. The bench drives every input on a falling edge. Its monitor notes the strobes at each rising edge and compares the queued expectation at the next falling edge, so every check lands in the cycle its result is due.

// File: rtl/rb_pkg.sv
package rb_pkg;

    typedef enum logic [3:0] {
        A_RSV, A_RW, A_RO, A_WO, A_W1C, A_RC, A_SC, A_LH, A_LL
    } attr_t;

    typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} op_t;

    // Attribute placement per register and bit position
    function automatic attr_t attr_of(input int r, input int b);
        attr_t a;
        a = A_RSV;
        case (r)
            0: begin
                if (b <= 3)      a = A_RW;
                else if (b <= 5) a = A_WO;
                else if (b == 6) a = A_SC;
            end
            1: begin
                if (b <= 1)      a = A_RO;
                else if (b <= 3) a = A_W1C;
                else if (b <= 5) a = A_RC;
            end
            2: begin
                if (b <= 1)      a = A_LH;
                else if (b <= 3) a = A_LL;
            end
            default: a = A_RSV;
        endcase
        return a;
    endfunction

    // Bits that survive a software reset
    function automatic logic keeps(input int r, input int b);
        return ((r == 0) && (b == 2 || b == 3)) || ((r == 1) && (b == 3));
    endfunction

    // Stored reset value (latch-low bits store the inverted latch, so 0 reads as 1)
    function automatic logic dflt(input int r, input int b);
        return (r == 0) && (b == 0);
    endfunction

endpackage

// File: rtl/rb_bus_decode.sv
module rb_bus_decode #(
    parameter int AW   = 2,
    parameter int NREG = 4
) (
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    output rb_pkg::op_t     op,
    output logic [NREG-1:0] rd_sel,
    output logic [NREG-1:0] wr_sel
);
    import rb_pkg::*;

    always_comb begin
        if (bus_wr)      op = OP_WRITE;
        else if (bus_rd) op = OP_READ;
        else             op = OP_IDLE;
    end

    always_comb begin
        rd_sel = '0;
        wr_sel = '0;
        unique case (op)
            OP_READ:  rd_sel[bus_addr] = 1'b1;
            OP_WRITE: wr_sel[bus_addr] = 1'b1;
            OP_IDLE:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/rb_bit_cell.sv
module rb_bit_cell #(
    parameter rb_pkg::attr_t ATTR = rb_pkg::A_RW,
    parameter logic          KEEP = 1'b0,
    parameter logic          DFLT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic cond,
    output logic rd_val,
    output logic hw_val
);
    import rb_pkg::*;

    logic q, q_n;
    logic rel, rel_n;     // latch state: 0 held, 1 released
    logic soft_clr;

    assign soft_clr = sw_rst & ~KEEP;

    always_comb begin
        q_n   = q;
        rel_n = rel;
        unique case (ATTR)
            A_RW, A_WO: if (wr_hit) q_n = wr_bit;
            A_W1C:      q_n = cond | (q & ~(wr_hit & wr_bit));
            A_RC:       q_n = cond | (q & ~rd_hit);
            A_SC:       q_n = wr_hit & wr_bit;
            A_LH, A_LL: begin
                q_n   = cond | (q & ~(rd_hit | rel));
                rel_n = rd_hit | (rel & ~(cond & ~q));
            end
            default: begin
                q_n   = 1'b0;
                rel_n = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= DFLT;
            rel <= 1'b0;
        end else if (soft_clr) begin
            q   <= DFLT;
            rel <= 1'b0;
        end else begin
            q   <= q_n;
            rel <= rel_n;
        end
    end

    always_comb begin
        unique case (ATTR)
            A_RW, A_W1C, A_RC, A_SC, A_LH: rd_val = q;
            A_LL:                          rd_val = ~q;
            A_RO:                          rd_val = cond;
            default:                       rd_val = 1'b0;
        endcase
    end

    always_comb begin
        unique case (ATTR)
            A_RW, A_WO, A_W1C, A_RC, A_SC, A_LH: hw_val = q;
            A_LL:                                hw_val = ~q;
            default:                             hw_val = 1'b0;
        endcase
    end

    generate
        if (ATTR == A_RW) begin : g_chk_rw
            a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
                wr_hit |=> (q == $past(wr_bit)));
        end
        if (ATTR == A_SC) begin : g_chk_sc
            a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                q |=> !q);
        end
        if (ATTR == A_W1C) begin : g_chk_w1c
            a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
                cond |=> q);
            a_r6_one_clears: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
                (wr_hit && wr_bit && !cond) |=> !q);
        end
        if (ATTR == A_RC) begin : g_chk_rc
            a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
                cond |=> q);
            a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
                (rd_hit && !cond) |=> !q);
        end
        if (ATTR == A_LH || ATTR == A_LL) begin : g_chk_latch
            a_r8_r9_catch: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
                cond |=> q);
            a_r8_r9_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
                (q && !rd_hit && !rel) |=> q);
        end
    endgenerate

endmodule

// File: rtl/rb_attr_bank.sv
module rb_attr_bank #(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sw_rst,
    input  logic [AW-1:0]            bus_addr,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    input  logic [(1<<AW)*DW-1:0]    hw_cond,
    output logic [(1<<AW)*DW-1:0]    hw_q
);
    import rb_pkg::*;

    localparam int NREG = 1 << AW;
    localparam int NBIT = NREG * DW;

    op_t              op;
    logic [NREG-1:0]  rd_sel, wr_sel;
    logic [NBIT-1:0]  rd_vals;

    rb_bus_decode #(.AW(AW), .NREG(NREG)) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .op       (op),
        .rd_sel   (rd_sel),
        .wr_sel   (wr_sel)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        for (genvar b = 0; b < DW; b++) begin : g_bit
            rb_bit_cell #(
                .ATTR (attr_of(r, b)),
                .KEEP (keeps(r, b)),
                .DFLT (dflt(r, b))
            ) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .sw_rst (sw_rst),
                .rd_hit (rd_sel[r]),
                .wr_hit (wr_sel[r]),
                .wr_bit (bus_wdata[b]),
                .cond   (hw_cond[r*DW+b]),
                .rd_val (rd_vals[r*DW+b]),
                .hw_val (hw_q[r*DW+b])
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (op == OP_READ)
            bus_rdata <= rd_vals[int'(bus_addr)*DW +: DW];
    end

    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_READ) |=> $stable(bus_rdata));

endmodule

// File: tb/test_rb_attr_bank.sv
`timescale 1ns/1ps
module test_rb_attr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] hw_cond = '0;
    logic [31:0] hw_q;

    int checks = 0;
    int errors = 0;

    typedef struct { logic [7:0] exp; string req; } item_t;
    item_t sbq[$];

    always #2.5 clk = ~clk;

    rb_attr_bank i_rb_attr_bank (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .hw_cond(hw_cond), .hw_q(hw_q)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: reads sampled at a rising edge are compared at the next falling edge
    initial begin
        forever begin
            logic fired;
            @(posedge clk);
            fired = bus_rd && !bus_wr && rst_n;
            @(negedge clk);
            if (fired) begin
                if (sbq.size() == 0) begin
                    errors++;
                    $display("FAIL R1 unexpected read actual=%h expected=none", bus_rdata);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk(bus_rdata, it.exp, it.req);
                end
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        sbq.push_back('{exp, req});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        hw_cond[idx] = 1'b1;
        @(negedge clk);
        hw_cond[idx] = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        rd(0, 8'h01, "R2 R12 reset reg0");
        rd(1, 8'h00, "R12 reset reg1");
        rd(2, 8'h0C, "R9 latch-low default high");
        rd(3, 8'h00, "R10 reserved register");

        // R2 R3 R4 R10: write control register
        wr(0, 8'hFA);
        chk(hw_q[7:0], 8'h7A, "R3 R4 hw_q after write");
        @(negedge clk);
        chk(hw_q[7:0], 8'h3A, "R4 self-clear after one cycle");
        rd(0, 8'h0A, "R2 R3 R4 R10 readback");
        wr(0, 8'h05);
        chk(hw_q[7:0], 8'h05, "R4 zero write no pulse");
        rd(0, 8'h05, "R2 readback");

        // R5 read-only
        @(negedge clk); hw_cond[9:8] = 2'b10;
        rd(1, 8'h02, "R5 live value");
        wr(1, 8'h03);
        rd(1, 8'h02, "R5 write ignored");
        @(negedge clk); hw_cond[9:8] = 2'b00;

        // R6 write-one-to-clear
        pulse(10);
        rd(1, 8'h04, "R6 set");
        wr(1, 8'h00);
        rd(1, 8'h04, "R6 zero write no effect");
        wr(1, 8'h04);
        rd(1, 8'h00, "R6 one clears");
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'h04; bus_wr = 1'b1; hw_cond[10] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; hw_cond[10] = 1'b0;
        rd(1, 8'h04, "R6 set wins over clear");
        wr(1, 8'h04);

        // R7 clear-on-read
        pulse(12);
        rd(1, 8'h10, "R7 pre-clear value");
        rd(1, 8'h00, "R7 cleared by read");
        pulse(13);
        wr(1, 8'hFF);
        rd(1, 8'h20, "R7 R10 write ignored");
        rd(1, 8'h00, "R7 cleared");
        pulse(12);
        @(negedge clk);
        bus_addr = 2'd1; bus_rd = 1'b1; hw_cond[12] = 1'b1;
        sbq.push_back('{8'h10, "R7 read during set"});
        @(negedge clk);
        bus_rd = 1'b0; hw_cond[12] = 1'b0;
        rd(1, 8'h10, "R7 set wins over read clear");
        rd(1, 8'h00, "R7 cleared after");

        // R8 latch-high
        pulse(16);
        rd(2, 8'h0D, "R8 held after cause gone");
        rd(2, 8'h0C, "R8 released by read");
        @(negedge clk); hw_cond[16] = 1'b1;
        @(negedge clk);
        rd(2, 8'h0D, "R8 cause present");
        @(negedge clk); hw_cond[16] = 1'b0;
        @(negedge clk);
        rd(2, 8'h0C, "R8 follows cause after read");

        // R9 latch-low
        pulse(18);
        rd(2, 8'h08, "R9 held low");
        rd(2, 8'h0C, "R9 rises after read");

        // R10 reserved register writes
        wr(3, 8'hFF);
        rd(3, 8'h00, "R10 reserved write ignored");

        // R11 software reset
        wr(0, 8'h3F);
        chk(hw_q[7:0], 8'h3F, "R3 write-only stored");
        pulse(10); pulse(11); pulse(16);
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk); sw_rst = 1'b0;
        chk(hw_q[7:0], 8'h0D, "R11 reg0 after soft reset");
        rd(0, 8'h0D, "R11 reg0 kept bits");
        rd(1, 8'h08, "R11 reg1 kept bit");
        rd(2, 8'h0C, "R11 reg2 defaults");

        // R12 hardware reset
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(0, 8'h01, "R12 reg0 default");
        rd(1, 8'h00, "R12 reg1 default");

        // R1 read and write together: write only, rdata holds
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'h02; bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        chk(bus_rdata, 8'h00, "R1 rdata held on collision");
        repeat (2) @(negedge clk);
        chk(bus_rdata, 8'h00, "R1 rdata held when idle");
        rd(0, 8'h02, "R1 collision write applied");

        repeat (2) @(negedge clk);
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R1 pending reads actual=%0d expected=0", sbq.size());
        end
        summary();
        $finish;
    end

endmodule